// File: doc/BRIEF.md
# Ring Frequency Validation Controller

This block checks that ringing on a telephone line has a legal cadence before it reports a ring. Two synchronized comparator flags come in. One rises when the line passes the positive ring threshold, and the other rises when it passes the negative threshold. The block times the gap between crossings of alternate polarity against a programmable minimum and maximum. It then requires that gap to stay legal for a qualify window.

After qualification the block stops checking frequency and watches only for the end of ring. The end of ring is a period with no crossing at all. A delay timer then races the end-of-ring timeout. Only a delay that finishes first raises the ring envelope. The envelope drives a sticky interrupt flag, an interrupt pin with selectable polarity, and a ring-detect pin. The ring-detect pin can instead carry an unqualified fixed-length one-shot.

Every parameter is a plain input port. All timing counts a shared timebase tick of about 1 ms. Control and status are plain level pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `ring_validator`

## Requirements
- R1: An interval is the number of ticks between two crossings of opposite polarity. A rising edge on the flag of the polarity seen last is ignored for interval timing and does not restart the interval.
- R2: In the qualify phase, an interval that grows past `max_ivl` ticks is too slow. The block returns to idle and no valid ring can follow from that attempt.
- R3: An alternate crossing that ends an interval shorter than `min_ivl` ticks is too fast. It restarts the qualify window from zero.
- R4: Frequency counts as validated once the qualify window reaches `qual_len*QUAL_STEP` ticks with no too-fast restart. From then on, interval limits are no longer checked.
- R5: On validation, a delay of `dly_len*DLY_STEP` ticks starts. The envelope rises only if the delay ends before `end_tmo*TMO_STEP` ticks pass with no crossing. If the timeout comes first, or both end together, the block returns to idle with no ring.
- R6: With `val_en`=1, `ring_env` is high from valid-ring assertion until `end_tmo*TMO_STEP` ticks pass after the most recent crossing of either polarity.
- R7: With `val_en`=0, the validator is held idle. `ring_env` then rises on any crossing and falls after the same end-of-ring timeout, with no frequency check.
- R8: `irq_flag` sets on a rising edge of `ring_env`. When `both_edge`=1 it also sets on a falling edge. It stays set until a one-cycle `irq_clr` pulse, and a set event in the same cycle wins over the clear.
- R9: `irq_pin` equals `irq_flag` when `irq_pol`=1 and its inverse when `irq_pol`=0.
- R10: With `pin_sel`=0, `rd_pin` follows `ring_env`. With `pin_sel`=1, `rd_pin` follows a one-shot. The one-shot starts on any crossing while idle, does not retrigger, and ends after `ONESHOT_TICKS` ticks.
- R11: While `rst` is high at a clock edge, the envelope, flag, one-shot and all counters clear and the validator goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse |
| pos_cross | input | 1 | Positive threshold comparator flag |
| neg_cross | input | 1 | Negative threshold comparator flag |
| val_en | input | 1 | Frequency validation enable |
| min_ivl | input | 6 | Shortest legal interval, ticks |
| max_ivl | input | 6 | Longest legal interval, ticks |
| qual_len | input | 3 | Qualify window, units of QUAL_STEP ticks |
| dly_len | input | 3 | Valid-ring delay, units of DLY_STEP ticks |
| end_tmo | input | 4 | End-of-ring timeout, units of TMO_STEP ticks |
| both_edge | input | 1 | Interrupt on both envelope edges |
| irq_pol | input | 1 | Interrupt pin polarity, 1 = active high |
| irq_clr | input | 1 | One-cycle flag clear |
| pin_sel | input | 1 | Ring-detect pin source, 1 = one-shot |
| ring_env | output | 1 | Ring envelope status |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_pin | output | 1 | Interrupt pin |
| rd_pin | output | 1 | Ring-detect pin |

## Verification
Random bursts of alternating crossings are drawn from three interval bands: too fast, in band and too slow. Each band pairs with either a long burst or a short one. Only an in-band long burst may raise the envelope. The too-fast band separates the minimum check from the maximum check, and the short bursts separate the delay-versus-timeout race from frequency qualification. Directed cases add extra same-polarity pulses inside a legal cadence, which fails only if repeats restart the interval. They also cover raw mode with validation disabled, and both pin sources and both polarities across the envelope's rising and falling edges.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUAL  = 2'd1,
    ST_DLY   = 2'd2,
    ST_VALID = 2'd3
  } ring_st_e;
endpackage

// File: rtl/ring_edge_det.sv
module ring_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] ev
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) prev[g] <= 1'b0;
      else     prev[g] <= lvl[g];
    end
    assign ev[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/ring_freq_fsm.sv
module ring_freq_fsm
  import ring_pkg::*;
#(
  parameter int QUAL_STEP = 16,
  parameter int DLY_STEP  = 16,
  parameter int TMO_STEP  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       val_en,
  input  logic       pos_ev,
  input  logic       neg_ev,
  input  logic [5:0] min_ivl,
  input  logic [5:0] max_ivl,
  input  logic [2:0] qual_len,
  input  logic [2:0] dly_len,
  input  logic [3:0] end_tmo,
  output logic       env
);
  localparam int IW = 7;
  localparam int QW = $clog2(7 * QUAL_STEP + 2);
  localparam int DW = $clog2(7 * DLY_STEP + 2);
  localparam int EW = $clog2(15 * TMO_STEP + 2);

  ring_st_e        state;
  logic [IW-1:0]   ivl_cnt;
  logic [QW-1:0]   qual_tmr;
  logic [DW-1:0]   dly_tmr;
  logic [EW-1:0]   eot_tmr;
  logic            last_neg;
  logic            raw_act;
  logic [QW-1:0]   qual_tgt;
  logic [DW-1:0]   dly_tgt;
  logic [EW-1:0]   eot_tgt;
  logic            any_ev, alt_ev, eot_hit, too_fast, too_slow;

  assign qual_tgt = QW'(qual_len) * QW'(QUAL_STEP);
  assign dly_tgt  = DW'(dly_len) * DW'(DLY_STEP);
  assign eot_tgt  = EW'(end_tmo) * EW'(TMO_STEP);

  assign any_ev   = pos_ev | neg_ev;
  assign alt_ev   = (pos_ev & last_neg) | (neg_ev & ~last_neg);
  assign eot_hit  = (eot_tmr >= eot_tgt) & ~any_ev;
  assign too_fast = ivl_cnt < {1'b0, min_ivl};
  assign too_slow = ivl_cnt > {1'b0, max_ivl};

  // time since most recent crossing of either polarity
  always_ff @(posedge clk) begin
    if (rst)                           eot_tmr <= '0;
    else if (any_ev)                   eot_tmr <= '0;
    else if (tick && eot_tmr != '1)    eot_tmr <= eot_tmr + 1'b1;
  end

  // unqualified envelope used when validation is off
  always_ff @(posedge clk) begin
    if (rst)          raw_act <= 1'b0;
    else if (any_ev)  raw_act <= 1'b1;
    else if (eot_hit) raw_act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ivl_cnt  <= '0;
      qual_tmr <= '0;
      dly_tmr  <= '0;
      last_neg <= 1'b0;
    end else if (!val_en) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (any_ev) begin
            state    <= ST_QUAL;
            last_neg <= neg_ev & ~pos_ev;
            ivl_cnt  <= '0;
            qual_tmr <= '0;
          end
        end
        ST_QUAL: begin
          if (alt_ev) begin
            last_neg <= ~last_neg;
            ivl_cnt  <= '0;
            if (too_fast)                       qual_tmr <= '0;
            else if (tick && qual_tmr != '1)    qual_tmr <= qual_tmr + 1'b1;
          end else if (too_slow) begin
            state <= ST_IDLE;
          end else if (qual_tmr >= qual_tgt) begin
            state   <= ST_DLY;
            dly_tmr <= '0;
          end else if (tick) begin
            if (ivl_cnt != '1)  ivl_cnt  <= ivl_cnt + 1'b1;
            if (qual_tmr != '1) qual_tmr <= qual_tmr + 1'b1;
          end
        end
        ST_DLY: begin
          if (eot_hit)                  state <= ST_IDLE;
          else if (dly_tmr >= dly_tgt)  state <= ST_VALID;
          else if (tick)                dly_tmr <= dly_tmr + 1'b1;
        end
        ST_VALID: begin
          if (eot_hit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign env = val_en ? (state == ST_VALID) : raw_act;

  p_valid_via_delay_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_VALID) |-> $past(state == ST_DLY));

  p_qual_on_cross_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_QUAL) |-> $past(pos_ev | neg_ev));

  p_off_goes_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !val_en |=> state == ST_IDLE);

  p_env_drop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (val_en && $past(val_en) && $fell(env)) |-> $past(eot_tmr >= eot_tgt));
endmodule

// File: rtl/ring_irq.sv
module ring_irq (
  input  logic clk,
  input  logic rst,
  input  logic env,
  input  logic both_edge,
  input  logic irq_pol,
  input  logic irq_clr,
  output logic irq_flag,
  output logic irq_pin
);
  logic env_d, set_ev;

  always_ff @(posedge clk) begin
    if (rst) env_d <= 1'b0;
    else     env_d <= env;
  end

  assign set_ev = (env & ~env_d) | (both_edge & ~env & env_d);

  always_ff @(posedge clk) begin
    if (rst)          irq_flag <= 1'b0;
    else if (set_ev)  irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  assign irq_pin = irq_pol ? irq_flag : ~irq_flag;

  p_rise_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (env && !env_d) |=> irq_flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

// File: rtl/ring_oneshot.sv
module ring_oneshot #(
  parameter int LEN_TICKS = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  output logic active
);
  localparam int OW = $clog2(LEN_TICKS + 1);
  logic [OW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (cnt == '0 && trig)  cnt <= OW'(LEN_TICKS);
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = cnt != '0;

  p_shot_starts_on_cross_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(trig));
endmodule

// File: rtl/ring_validator.sv
module ring_validator #(
  parameter int QUAL_STEP     = 16,
  parameter int DLY_STEP      = 16,
  parameter int TMO_STEP      = 16,
  parameter int ONESHOT_TICKS = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       pos_cross,
  input  logic       neg_cross,
  input  logic       val_en,
  input  logic [5:0] min_ivl,
  input  logic [5:0] max_ivl,
  input  logic [2:0] qual_len,
  input  logic [2:0] dly_len,
  input  logic [3:0] end_tmo,
  input  logic       both_edge,
  input  logic       irq_pol,
  input  logic       irq_clr,
  input  logic       pin_sel,
  output logic       ring_env,
  output logic       irq_flag,
  output logic       irq_pin,
  output logic       rd_pin
);
  logic [1:0] ev;
  logic       shot;

  ring_edge_det #(.N(2)) u_edge (
    .clk (clk), .rst (rst),
    .lvl ({neg_cross, pos_cross}),
    .ev  (ev)
  );

  ring_freq_fsm #(
    .QUAL_STEP (QUAL_STEP), .DLY_STEP (DLY_STEP), .TMO_STEP (TMO_STEP)
  ) u_fsm (
    .clk (clk), .rst (rst), .tick (tick), .val_en (val_en),
    .pos_ev (ev[0]), .neg_ev (ev[1]),
    .min_ivl (min_ivl), .max_ivl (max_ivl), .qual_len (qual_len),
    .dly_len (dly_len), .end_tmo (end_tmo),
    .env (ring_env)
  );

  ring_irq u_irq (
    .clk (clk), .rst (rst), .env (ring_env), .both_edge (both_edge),
    .irq_pol (irq_pol), .irq_clr (irq_clr),
    .irq_flag (irq_flag), .irq_pin (irq_pin)
  );

  ring_oneshot #(.LEN_TICKS (ONESHOT_TICKS)) u_shot (
    .clk (clk), .rst (rst), .tick (tick), .trig (|ev), .active (shot)
  );

  assign rd_pin = pin_sel ? shot : ring_env;
endmodule

// File: tb/ring_validator_tb.sv
`timescale 1ns/1ps
module ring_validator_tb;
  localparam int MIN_I = 4, MAX_I = 12;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic pos_cross = 1'b0, neg_cross = 1'b0, val_en = 1'b1;
  logic [5:0] min_ivl = 6'(MIN_I), max_ivl = 6'(MAX_I);
  logic [2:0] qual_len = 3'd2, dly_len = 3'd3;
  logic [3:0] end_tmo = 4'd2;
  logic both_edge = 1'b0, irq_pol = 1'b1, irq_clr = 1'b0, pin_sel = 1'b0;
  logic ring_env, irq_flag, irq_pin, rd_pin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_validator #(.QUAL_STEP(8), .DLY_STEP(8), .TMO_STEP(8), .ONESHOT_TICKS(300)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .pos_cross(pos_cross), .neg_cross(neg_cross),
    .val_en(val_en), .min_ivl(min_ivl), .max_ivl(max_ivl), .qual_len(qual_len),
    .dly_len(dly_len), .end_tmo(end_tmo), .both_edge(both_edge), .irq_pol(irq_pol),
    .irq_clr(irq_clr), .pin_sel(pin_sel), .ring_env(ring_env), .irq_flag(irq_flag),
    .irq_pin(irq_pin), .rd_pin(rd_pin));

  initial begin : g_tick
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pulse(input logic neg);
    @(negedge clk);
    if (neg) neg_cross = 1'b1; else pos_cross = 1'b1;
    @(negedge clk);
    neg_cross = 1'b0; pos_cross = 1'b0;
  endtask

  // alternating crossings every h ticks for about dur ticks; rep adds same-polarity repeats
  task automatic burst(input int h, input int dur, input bit rep);
    int t = 0;
    logic pol = 1'b0;
    forever begin
      @(negedge clk);
      if (pol) neg_cross = 1'b1; else pos_cross = 1'b1;
      @(negedge clk);
      neg_cross = 1'b0; pos_cross = 1'b0;
      if (t + h > dur) break;
      if (rep) begin
        repeat (7) @(negedge clk);
        pulse(pol);
        repeat (h * 4 - 11) @(negedge clk);
      end else begin
        repeat (h * 4 - 2) @(negedge clk);
      end
      t += h;
      pol = ~pol;
    end
  endtask

  function automatic logic exp_ring(input logic en, input int h, input int dur);
    if (!en) return 1'b1;
    return (h > MIN_I && h < MAX_I && dur >= 60);
  endfunction

  task automatic clear_flag();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // one full scenario with checks on all outputs
  task automatic scenario(input string tag, input int h, input int dur, input bit rep);
    logic e;
    e = exp_ring(val_en, h, dur);
    clear_flag();
    burst(h, dur, rep);
    chk({tag, " R6 env at burst end"}, ring_env, e);
    chk({tag, " R8 flag after rise"}, irq_flag, e);
    chk({tag, " R9 pin polarity"}, irq_pin, irq_pol ? irq_flag : ~irq_flag);
    chk({tag, " R10 rd_pin in burst"}, rd_pin, pin_sel ? 1'b1 : e);
    clear_flag();
    wait_ticks(30);
    chk({tag, " R6 env after end timeout"}, ring_env, 1'b0);
    chk({tag, " R8 flag on fall"}, irq_flag, e & both_edge);
    chk({tag, " R10 rd_pin after end"}, rd_pin, pin_sel);
    wait_ticks(300);
    chk({tag, " R10 one-shot expired"}, rd_pin, 1'b0);
  endtask

  initial begin : g_main
    int h;
    void'($urandom(32'h1234_5678));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset env", ring_env, 1'b0);
    chk("R11 reset flag", irq_flag, 1'b0);
    chk("R11 reset rd_pin", rd_pin, 1'b0);
    chk("R11 reset irq_pin", irq_pin, 1'b0);

    scenario("R4 in-band long", 8, 90, 0);
    scenario("R3 too fast", 2, 90, 0);
    scenario("R2 too slow", 17, 120, 0);
    scenario("R5 short burst", 6, 18, 0);
    scenario("R1 same-polarity repeats", 8, 90, 1);
    both_edge = 1'b1; pin_sel = 1'b1; irq_pol = 1'b0;
    scenario("R8 both edges", 7, 90, 0);
    val_en = 1'b0;
    scenario("R7 raw mode", 2, 18, 0);
    val_en = 1'b1;

    for (int i = 0; i < 14; i++) begin
      case ($urandom_range(0, 2))
        0: h = $urandom_range(2, 3);
        1: h = $urandom_range(6, 10);
        default: h = $urandom_range(15, 20);
      endcase
      both_edge = 1'($urandom_range(0, 1));
      irq_pol   = 1'($urandom_range(0, 1));
      pin_sel   = 1'($urandom_range(0, 1));
      scenario("R4 random", h, $urandom_range(0, 1) ? 90 : 18, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : g_watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired R4 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule